// File: doc/BRIEF.md
# Dual-Line Serial ADC Capture Controller

This block is the synchronous master for a simultaneous-sampling converter that delivers two conversion results on two separate serial data lines. It pulls chip-select low, waits a programmable setup time, then toggles a 50% duty-cycle serial clock derived from the system clock. Both data lines are shifted in side by side, and each frame is exactly `FRAME_BITS` serial clock periods long.

When chip-select returns high, the two captured words appear together with a one-cycle valid strobe. A guard timer then keeps chip-select high for the longer of the minimum high time and the quiet time before another frame may begin. A frame can be launched by a start pulse or by a free-running enable. A start that arrives during a frame is either remembered or dropped, as a parameter selects.

At elaboration the block rejects any parameter set that would give a serial clock outside 1 to 32 MHz, or a setup, high or quiet time shorter than 30 ns.

Top module: `dual_adc_capture`

## Requirements
- R1: A frame holds chip-select low for exactly SETUP_CYC + 2·HALF_CYC·FRAME_BITS system cycles and gives exactly FRAME_BITS rising serial clock edges.
- R2: Between two frames chip-select stays high for at least GAP_CYC cycles, where GAP_CYC is the larger of CSH_CYC and QUIET_CYC.
- R3: Chip-select falls SETUP_CYC cycles before the first falling serial clock edge, and the serial clock stays high during the setup time.
- R4: The serial clock is high whenever chip-select is high. Inside a frame it is low for HALF_CYC cycles, then high for HALF_CYC cycles, starting with the low half.
- R5: Both data lines are sampled at the system clock edge on which the serial clock rises, MSB first. Each output word holds the last RES_BITS bits of the frame, with the earliest of those bits in the MSB.
- R6: data_valid is high for exactly one cycle: the cycle in which chip-select has just returned high. It comes together with both new words, and the words hold their value until the next strobe.
- R7: busy rises together with chip-select's fall and falls GAP_CYC cycles after chip-select rises. A start is accepted only while busy is low.
- R8: With HOLD_PENDING=1, a start seen while busy is stored, and the next frame begins on the first cycle after busy falls. With HOLD_PENDING=0, such a start has no effect.
- R9: While free_run is high, a new frame begins on the first cycle after each time busy falls.
- R10: After reset, chip-select and the serial clock are high, busy and data_valid are low, and both words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion frame |
| free_run_i | input | 1 | Launch frames back to back while high |
| miso_a_i | input | 1 | Serial data line A from the converter |
| miso_b_i | input | 1 | Serial data line B from the converter |
| cs_n_o | output | 1 | Active-low chip-select |
| sclk_o | output | 1 | Serial clock, idle high |
| data_a_o | output | RES_BITS | Captured word from line A |
| data_b_o | output | RES_BITS | Captured word from line B |
| data_valid_o | output | 1 | One-cycle strobe for new words |
| busy_o | output | 1 | Frame or guard gap in progress |

## Verification
The data lines are driven with random bits, all ones, all zeros, and with line B as the complement of a toggling line A. All ones and all zeros expose a dropped or extra shift and a stuck lane. Random bits reveal an off-by-one in the sampling edge or in which bits are kept. Complementary toggling catches lanes that are swapped or cross-wired. Single starts, a start arriving mid-frame, a start held high and free-running operation separate the holding and dropping variants and test the guard gap.

// File: rtl/dadc_pkg.sv
package dadc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_GAP
    } dadc_state_e;
endpackage

// File: rtl/dadc_down_counter.sv
module dadc_down_counter #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // an expired guard stays expired until reloaded
    AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (zero_o && !load_i) |=> zero_o); // R3
endmodule

// File: rtl/dadc_shift_lane.sv
module dadc_shift_lane #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         shift_i,
    input  logic         din_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (shift_i)
            word_d = {word_q[W-2:0], din_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) word_q <= '0;
        else         word_q <= word_d;
    end

    assign word_o = word_q;
endmodule

// File: rtl/dual_adc_capture.sv
module dual_adc_capture
    import dadc_pkg::*;
#(
    parameter int CLK_MHZ      = 50,
    parameter int HALF_CYC     = 2,
    parameter int SETUP_CYC    = 2,
    parameter int CSH_CYC      = 2,
    parameter int QUIET_CYC    = 2,
    parameter int FRAME_BITS   = 14,
    parameter int RES_BITS     = 12,
    parameter bit HOLD_PENDING = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic                free_run_i,
    input  logic                miso_a_i,
    input  logic                miso_b_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic [RES_BITS-1:0] data_a_o,
    output logic [RES_BITS-1:0] data_b_o,
    output logic                data_valid_o,
    output logic                busy_o
);
    localparam int GAP_CYC = (CSH_CYC > QUIET_CYC) ? CSH_CYC : QUIET_CYC;
    localparam int TMAX    = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
    localparam int CW      = $clog2(TMAX + 1);
    localparam int PW      = $clog2(HALF_CYC + 1);
    localparam int BW      = $clog2(FRAME_BITS + 1);
    localparam int LANES   = 2;

    // elaboration guards: SCLK within 1..32 MHz, every guard at least 30 ns
    if (CLK_MHZ > 64 * HALF_CYC || CLK_MHZ < 2 * HALF_CYC)
        $error("serial clock outside 1..32 MHz");
    if (SETUP_CYC * 1000 < 30 * CLK_MHZ || SETUP_CYC < 1)
        $error("setup time too short");
    if (CSH_CYC * 1000 < 30 * CLK_MHZ || QUIET_CYC * 1000 < 30 * CLK_MHZ || GAP_CYC < 1)
        $error("chip-select high or quiet time too short");
    if (RES_BITS < 2 || RES_BITS > FRAME_BITS)
        $error("result width must fit in the frame");

    typedef struct packed {
        dadc_state_e         st;
        logic                cs_n;
        logic                sclk;
        logic [BW-1:0]       bits;
        logic                pend;
        logic                busy;
        logic                valid;
        logic [RES_BITS-1:0] out_a;
        logic [RES_BITS-1:0] out_b;
    } regs_t;

    regs_t r_d, r_q;

    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;
    logic          ph_load, ph_zero;
    logic          shift_en;
    logic [LANES-1:0]               lane_din;
    logic [LANES-1:0][RES_BITS-1:0] lane_word;

    assign lane_din = {miso_b_i, miso_a_i};

    dadc_down_counter #(.W(CW)) i_guard_tmr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    dadc_down_counter #(.W(PW)) i_phase_tmr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (ph_load),
        .load_val_i (PW'(HALF_CYC - 1)),
        .zero_o     (ph_zero)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dadc_shift_lane #(.W(RES_BITS)) i_lane (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .shift_i (shift_en),
            .din_i   (lane_din[g]),
            .word_o  (lane_word[g])
        );
    end

    always_comb begin
        r_d      = r_q;
        r_d.valid = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ph_load  = 1'b0;
        shift_en = 1'b0;

        if (HOLD_PENDING && start_i && r_q.st != ST_IDLE)
            r_d.pend = 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i || free_run_i || r_q.pend) begin
                    r_d.st   = ST_SETUP;
                    r_d.cs_n = 1'b0;
                    r_d.busy = 1'b1;
                    r_d.pend = 1'b0;
                    r_d.bits = '0;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    r_d.st   = ST_SHIFT;
                    r_d.sclk = 1'b0;
                    ph_load  = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (ph_zero) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                        r_d.bits = r_q.bits + 1'b1;
                        shift_en = 1'b1;
                        ph_load  = 1'b1;
                    end else if (r_q.bits == BW'(FRAME_BITS)) begin
                        r_d.st    = ST_GAP;
                        r_d.cs_n  = 1'b1;
                        r_d.valid = 1'b1;
                        r_d.out_a = lane_word[0];
                        r_d.out_b = lane_word[1];
                        tmr_load  = 1'b1;
                        tmr_val   = CW'(GAP_CYC - 1);
                    end else begin
                        r_d.sclk = 1'b0;
                        ph_load  = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.sclk  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o       = r_q.cs_n;
    assign sclk_o       = r_q.sclk;
    assign data_a_o     = r_q.out_a;
    assign data_b_o     = r_q.out_b;
    assign data_valid_o = r_q.valid;
    assign busy_o       = r_q.busy;

    // run length of chip-select high, saturating, for the gap check
    localparam int HW = $clog2(GAP_CYC + 2);
    logic [HW-1:0] hi_run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       hi_run_q <= HW'(GAP_CYC + 1);
        else if (!r_q.cs_n)                hi_run_q <= '0;
        else if (hi_run_q != HW'(GAP_CYC + 1)) hi_run_q <= hi_run_q + 1'b1;
    end

    AST_CS_GAP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cs_n_o) |-> (hi_run_q >= HW'(GAP_CYC))); // R2
    AST_SETUP_SCLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cs_n_o) |-> sclk_o); // R3
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n_o |-> sclk_o); // R4
    AST_BIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.bits <= BW'(FRAME_BITS)); // R1
    AST_VALID_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_valid_o |-> $rose(cs_n_o)); // R6
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_valid_o |=> !data_valid_o); // R6
    AST_WORDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !data_valid_o |-> ($stable(data_a_o) && $stable(data_b_o))); // R6
    AST_BUSY_WITH_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_n_o |-> busy_o); // R7
endmodule

// File: tb/test_dual_adc_capture.sv
`timescale 1ns/1ps

module dadc_ref_model #(
    parameter int S = 2, H = 2, G = 2, FRAME = 14, RES = 12,
    parameter bit HOLD = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           free_run,
    input  logic           din_a,
    input  logic           din_b,
    output logic           e_cs_n,
    output logic           e_sclk,
    output logic           e_valid,
    output logic           e_busy,
    output logic [RES-1:0] e_a,
    output logic [RES-1:0] e_b
);
    localparam int FE = S + 2 * H * FRAME;
    int m_t;
    bit m_busy, m_pend;
    logic [RES-1:0] sa, sb;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_t = 0; m_busy = 0; m_pend = 0; sa = '0; sb = '0;
            e_a = '0; e_b = '0;
        end else begin
            if (m_busy) begin
                if (start && HOLD) m_pend = 1;
                m_t = m_t + 1;
                if (m_t == FE + G) m_busy = 0;
            end else if (start || free_run || m_pend) begin
                m_busy = 1; m_pend = 0; m_t = 0;
            end
            if (m_busy && m_t >= S && m_t < FE && ((m_t - S) % (2 * H)) == H) begin
                sa = {sa[RES-2:0], din_a};
                sb = {sb[RES-2:0], din_b};
            end
            if (m_busy && m_t == FE) begin
                e_a = sa; e_b = sb;
            end
        end
        e_busy  = m_busy;
        e_cs_n  = !(m_busy && m_t < FE);
        e_valid = m_busy && m_t == FE;
        e_sclk  = (!m_busy || m_t < S || m_t >= FE) ? 1'b1 : (((m_t - S) % (2 * H)) >= H);
    end
endmodule

module test_dual_adc_capture;
    localparam int RES = 12;
    localparam int S = 2, H = 2, G = 2, FRAME = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, free_run = 1'b0;
    logic din_a = 1'b0, din_b = 1'b0;
    int   mode = 0;
    bit   cmp_on = 0;
    int   checks = 0, errors = 0;

    always #10 clk = ~clk;

    logic cs_p, sclk_p, val_p, busy_p, cs_d, sclk_d, val_d, busy_d;
    logic [RES-1:0] a_p, b_p, a_d, b_d;
    logic ecs_p, esclk_p, eval_p, ebusy_p, ecs_d, esclk_d, eval_d, ebusy_d;
    logic [RES-1:0] ea_p, eb_p, ea_d, eb_d;

    dual_adc_capture #(.HOLD_PENDING(1'b1)) i_dual_adc_capture (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .free_run_i(free_run),
        .miso_a_i(din_a), .miso_b_i(din_b), .cs_n_o(cs_p), .sclk_o(sclk_p),
        .data_a_o(a_p), .data_b_o(b_p), .data_valid_o(val_p), .busy_o(busy_p));

    dual_adc_capture #(.HOLD_PENDING(1'b0)) i_dual_adc_capture_drop (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .free_run_i(free_run),
        .miso_a_i(din_a), .miso_b_i(din_b), .cs_n_o(cs_d), .sclk_o(sclk_d),
        .data_a_o(a_d), .data_b_o(b_d), .data_valid_o(val_d), .busy_o(busy_d));

    dadc_ref_model #(.S(S), .H(H), .G(G), .FRAME(FRAME), .RES(RES), .HOLD(1'b1)) i_ref_p (
        .clk(clk), .rst_n(rst_n), .start(start), .free_run(free_run),
        .din_a(din_a), .din_b(din_b), .e_cs_n(ecs_p), .e_sclk(esclk_p),
        .e_valid(eval_p), .e_busy(ebusy_p), .e_a(ea_p), .e_b(eb_p));

    dadc_ref_model #(.S(S), .H(H), .G(G), .FRAME(FRAME), .RES(RES), .HOLD(1'b0)) i_ref_d (
        .clk(clk), .rst_n(rst_n), .start(start), .free_run(free_run),
        .din_a(din_a), .din_b(din_b), .e_cs_n(ecs_d), .e_sclk(esclk_d),
        .e_valid(eval_d), .e_busy(ebusy_d), .e_a(ea_d), .e_b(eb_d));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // data lines change away from the sampling edge
    always @(negedge clk) begin
        case (mode)
            0: begin din_a <= 1'($urandom % 2); din_b <= 1'($urandom % 2); end
            1: begin din_a <= 1'b1; din_b <= 1'b1; end
            2: begin din_a <= 1'b0; din_b <= 1'b0; end
            default: begin din_a <= ~din_a; din_b <= din_a; end
        endcase
    end

    // every-clock comparison against the reference model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1 R2 R3 cs_n hold", cs_p, ecs_p);
            chk("R4 sclk hold", sclk_p, esclk_p);
            chk("R6 valid hold", val_p, eval_p);
            chk("R7 R8 busy hold", busy_p, ebusy_p);
            chk("R5 data_a hold", a_p, ea_p);
            chk("R5 data_b hold", b_p, eb_p);
            chk("R1 R2 R3 cs_n drop", cs_d, ecs_d);
            chk("R4 sclk drop", sclk_d, esclk_d);
            chk("R6 valid drop", val_d, eval_d);
            chk("R7 R8 busy drop", busy_d, ebusy_d);
            chk("R5 data_a drop", a_d, ea_d);
            chk("R5 data_b drop", b_d, eb_d);
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    bit done = 0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int falls;
        logic prev;
        repeat (3) @(negedge clk);
        // R10: reset values
        chk("R10 cs_n", cs_p, 1'b1);
        chk("R10 sclk", sclk_p, 1'b1);
        chk("R10 busy", busy_p, 1'b0);
        chk("R10 valid", val_p, 1'b0);
        chk("R10 data", {a_p, b_p}, '0);
        rst_n = 1'b1;
        cmp_on = 1;
        repeat (3) @(negedge clk);

        // one frame per data pattern
        for (int m = 0; m < 4; m++) begin
            mode = m;
            pulse_start();
            repeat (75) @(negedge clk);
            if (m == 1) chk("R5 ones word", {a_p, b_p}, {2 * RES{1'b1}});
            if (m == 2) chk("R5 zeros word", {a_p, b_p}, '0);
            if (m == 3) chk("R5 lanes complementary", a_p ^ b_p, {RES{1'b1}});
        end

        // R8: start during a frame is held by one variant, dropped by the other
        mode = 0;
        pulse_start();
        repeat (9) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (52) @(negedge clk);
        chk("R8 held start launched", cs_p, 1'b0);
        chk("R8 dropped start ignored cs", cs_d, 1'b1);
        chk("R8 dropped start ignored busy", busy_d, 1'b0);
        repeat (75) @(negedge clk);

        // R7: start held high gives back-to-back frames, only when idle
        start = 1'b1;
        repeat (130) @(negedge clk);
        start = 1'b0;
        repeat (130) @(negedge clk);

        // R9: free-running launches a frame every GAP after busy falls
        falls = 0;
        prev = cs_p;
        @(negedge clk) free_run = 1'b1;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (prev && !cs_p) falls++;
            prev = cs_p;
        end
        free_run = 1'b0;
        chk("R9 free-run frame count", falls, 4);
        repeat (80) @(negedge clk);
        chk("R7 idle after free-run", busy_p, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule